// File: doc/BRIEF.md
# ECC-Protected Sub-Word Store Merge Unit

This block owns a small word-organised data array. Every 32-bit word is held together with seven check bits that correct any single flipped bit and detect any two flipped bits. Requesters issue one access at a time over a valid/ready handshake. An access is a read, or a store of a byte, a halfword or a full word.

A full aligned word store needs no knowledge of the old contents. Its check bits are computed from the incoming data, and the word is written on the accepting edge. A byte or halfword store has to keep the untouched bytes of its word. The unit therefore reads the containing word, corrects it, replaces the addressed bytes and re-encodes the result. It writes the word back on one later edge and holds a stall towards the requester until then.

Stores and reads only proceed while an input reports that the enclosing line is held exclusively. The read, correct and write of a merge happen on the same edge, so a loss of ownership can delay a merge but cannot split it. A fault-injection port flips chosen stored bits, so that the correction and detection paths can be exercised.

Top module: `ecc_merge_store`

## Requirements
- R1: After reset no response is pending, the stall is low, ready follows the ownership input, and every word reads as zero with no error flag.
- R2: A store with size code 2 at a byte address whose two low bits are zero is accepted and written on the same edge. It computes fresh check bits, raises no stall, and gives an error-free response on the next cycle. A later read returns the stored word.
- R3: A byte store (size code 0) replaces byte lane addr[1:0] with wdata[7:0]. A halfword store (size code 1) replaces lanes {1,0} when addr[1]=0 and lanes {3,2} when addr[1]=1, using wdata[15:0] with the low byte in the lower lane. All other bytes of the word keep their previous values.
- R4: After a byte or halfword store is accepted, the stall is high and ready is low for the following cycle. This lasts longer only while ownership is absent, and ready is never high while the stall is high.
- R5: No request is accepted while the ownership input is low. A pending merge waits while ownership is low, then reads and writes its word on a single edge once ownership is present.
- R6: The following are rejected with an alignment-error response, zero read data, and no change to the array: a halfword at an odd address, a word at an address with a non-zero addr[1:0], and size code 3.
- R7: A read of a word with one flipped stored bit returns the corrected data with the corrected flag set, and leaves the stored word as it was. A merge into such a word corrects it first and writes back a clean word, again raising the corrected flag.
- R8: A read of a word with two flipped stored bits returns zero data with the uncorrectable flag set. A merge into such a word is aborted, raises the uncorrectable flag, and leaves the stored word unchanged.
- R9: A full-word store over a corrupted word replaces it with a clean word and raises no error flag.
- R10: Every accepted request produces exactly one response, one cycle wide. For reads, word stores and rejections it appears one cycle after acceptance. For merges it appears one cycle after the write-back edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| own_excl_i | input | 1 | Line is held exclusively; gates acceptance and merge commit |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_write_i | input | 1 | 1 = store, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| req_wdata_i | input | 32 | Store data, right-aligned for narrow stores |
| stall_o | output | 1 | Sub-word merge in progress |
| rsp_valid_o | output | 1 | Response valid, one cycle |
| rsp_rdata_o | output | 32 | Corrected read data (zero otherwise) |
| rsp_err_align_o | output | 1 | Request rejected for alignment or size |
| rsp_corr_o | output | 1 | Single-bit error was corrected |
| rsp_uncorr_o | output | 1 | Double-bit error detected |
| inj_valid_i | input | 1 | Apply fault injection this cycle |
| inj_idx_i | input | IDX_W | Word index to corrupt |
| inj_flip_i | input | 39 | Stored bits to invert |

## Verification
A wrong byte-lane decode or a wrong merge select would show up in the read data of the next read of that word, one cycle after that read is accepted. A stuck or early-exiting merge state would show at ready and stall in the very next cycle, because the bench compares both against its own model every clock. A broken encoder or syndrome calculation shows up as a spurious or missing corrected or uncorrectable flag on the first read after a store or an injection. A merge that ignored ownership or wrote back after a double error would leave a word whose later reads disagree with the model's error class.

// File: rtl/ecc_merge_pkg.sv
package ecc_merge_pkg;
  localparam int DATA_W = 32;
  localparam int HAM_W  = 6;
  localparam int CW_W   = DATA_W + HAM_W + 1;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_BAD = 2'd3} size_e;
  typedef enum logic {S_IDLE = 1'b0, S_MERGE = 1'b1} state_e;

  // i-th non-power-of-two code position
  function automatic int data_pos(input int i);
    int n;
    data_pos = 0;
    n = 0;
    for (int p = 1; p < CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == i) data_pos = p;
        n++;
      end
    end
  endfunction

  function automatic logic [3:0] lane_mask(input size_e sz, input logic [1:0] off);
    case (sz)
      SZ_BYTE: lane_mask = 4'b0001 << off;
      SZ_HALF: lane_mask = off[1] ? 4'b1100 : 4'b0011;
      default: lane_mask = 4'b1111;
    endcase
  endfunction

  function automatic logic misaligned(input size_e sz, input logic [1:0] off);
    case (sz)
      SZ_BYTE: misaligned = 1'b0;
      SZ_HALF: misaligned = off[0];
      SZ_WORD: misaligned = (off != 2'b00);
      default: misaligned = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import ecc_merge_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CW_W-1:0]   cw_o
);
  always_comb begin
    logic [CW_W-1:0] c;
    logic            par;
    c = '0;
    for (int i = 0; i < DATA_W; i++) c[data_pos(i)] = data_i[i];
    for (int k = 0; k < HAM_W; k++) begin
      par = 1'b0;
      for (int p = 1; p < CW_W; p++)
        if (((p >> k) & 1) == 1 && p != (1 << k)) par = par ^ c[p];
      c[1 << k] = par;
    end
    c[0] = ^c[CW_W-1:1];
    cw_o = c;
  end
endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import ecc_merge_pkg::*;
(
  input  logic [CW_W-1:0]   cw_i,
  output logic [DATA_W-1:0] data_o,
  output logic              single_o,
  output logic              double_o
);
  logic [HAM_W-1:0] syn;
  logic             ovr;
  logic [CW_W-1:0]  fixed;

  always_comb begin
    syn = '0;
    for (int p = 1; p < CW_W; p++)
      if (cw_i[p]) syn = syn ^ HAM_W'(p);
    ovr = ^cw_i;
  end

  assign single_o = ovr && (syn <= HAM_W'(CW_W - 1));
  assign double_o = (!ovr && syn != '0) || (ovr && syn > HAM_W'(CW_W - 1));

  always_comb begin
    fixed = cw_i;
    if (single_o) fixed[syn] = ~cw_i[syn];
    for (int i = 0; i < DATA_W; i++) data_o[i] = fixed[data_pos(i)];
  end
endmodule

// File: rtl/ecc_word_array.sv
module ecc_word_array
  import ecc_merge_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [CW_W-1:0]  wcw_i,
  input  logic             inj_i,
  input  logic [IDX_W-1:0] inj_idx_i,
  input  logic [CW_W-1:0]  inj_flip_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [CW_W-1:0]  rcw_o
);
  logic [CW_W-1:0] mem_q [DEPTH];

  // all-zero codeword is a valid encoding of zero data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < DEPTH; w++) mem_q[w] <= '0;
    end else begin
      for (int w = 0; w < DEPTH; w++) begin
        if (we_i && widx_i == IDX_W'(w)) mem_q[w] <= wcw_i;
        else if (inj_i && inj_idx_i == IDX_W'(w)) mem_q[w] <= mem_q[w] ^ inj_flip_i;
      end
    end
  end

  assign rcw_o = mem_q[ridx_i];
endmodule

// File: rtl/ecc_merge_store.sv
module ecc_merge_store
  import ecc_merge_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int ADDR_W = IDX_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              own_excl_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              stall_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_err_align_o,
  output logic              rsp_corr_o,
  output logic              rsp_uncorr_o,
  input  logic              inj_valid_i,
  input  logic [IDX_W-1:0]  inj_idx_i,
  input  logic [CW_W-1:0]   inj_flip_i
);
  localparam int LANES = DATA_W / 8;

  state_e            state_q;
  logic [ADDR_W-1:0] h_addr_q;
  size_e             h_size_q;
  logic [DATA_W-1:0] h_data_q;

  size_e             req_size;
  logic              accept, bad_align, merging, commit;
  logic              full_wr, sub_wr;
  logic [IDX_W-1:0]  rd_idx;
  logic [CW_W-1:0]   rd_cw, wr_cw;
  logic [DATA_W-1:0] dec_data, merged, lane_data, enc_in;
  logic              dec_single, dec_double;
  logic [LANES-1:0]  be;
  logic              arr_we;

  assign req_size    = size_e'(req_size_i);
  assign merging     = (state_q == S_MERGE);
  assign req_ready_o = !merging && own_excl_i;
  assign stall_o     = merging;
  assign accept      = req_valid_i && req_ready_o;
  assign bad_align   = misaligned(req_size, req_addr_i[1:0]);
  assign full_wr     = accept && req_write_i && !bad_align && req_size == SZ_WORD;
  assign sub_wr      = accept && req_write_i && !bad_align && req_size != SZ_WORD;
  assign commit      = merging && own_excl_i;

  assign rd_idx = merging ? h_addr_q[ADDR_W-1:2] : req_addr_i[ADDR_W-1:2];

  ecc_word_array #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (arr_we),
    .widx_i     (merging ? h_addr_q[ADDR_W-1:2] : req_addr_i[ADDR_W-1:2]),
    .wcw_i      (wr_cw),
    .inj_i      (inj_valid_i),
    .inj_idx_i  (inj_idx_i),
    .inj_flip_i (inj_flip_i),
    .ridx_i     (rd_idx),
    .rcw_o      (rd_cw)
  );

  secded_dec u_dec (
    .cw_i     (rd_cw),
    .data_o   (dec_data),
    .single_o (dec_single),
    .double_o (dec_double)
  );

  // replicate narrow store data across lanes, then select per byte
  assign lane_data = (h_size_q == SZ_BYTE) ? {LANES{h_data_q[7:0]}} : {(LANES/2){h_data_q[15:0]}};
  assign be        = lane_mask(h_size_q, h_addr_q[1:0]);

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign merged[b*8 +: 8] = be[b] ? lane_data[b*8 +: 8] : dec_data[b*8 +: 8];
  end

  assign enc_in = merging ? merged : req_wdata_i;

  secded_enc u_enc (
    .data_i (enc_in),
    .cw_o   (wr_cw)
  );

  assign arr_we = full_wr || (commit && !dec_double);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      h_addr_q <= '0;
      h_size_q <= SZ_BYTE;
      h_data_q <= '0;
    end else if (sub_wr) begin
      state_q  <= S_MERGE;
      h_addr_q <= req_addr_i;
      h_size_q <= req_size;
      h_data_q <= req_wdata_i;
    end else if (commit) begin
      state_q  <= S_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o     <= 1'b0;
      rsp_rdata_o     <= '0;
      rsp_err_align_o <= 1'b0;
      rsp_corr_o      <= 1'b0;
      rsp_uncorr_o    <= 1'b0;
    end else begin
      rsp_valid_o     <= 1'b0;
      rsp_rdata_o     <= '0;
      rsp_err_align_o <= 1'b0;
      rsp_corr_o      <= 1'b0;
      rsp_uncorr_o    <= 1'b0;
      if (commit) begin
        rsp_valid_o  <= 1'b1;
        rsp_corr_o   <= dec_single;
        rsp_uncorr_o <= dec_double;
      end else if (accept && bad_align) begin
        rsp_valid_o     <= 1'b1;
        rsp_err_align_o <= 1'b1;
      end else if (accept && !req_write_i) begin
        rsp_valid_o  <= 1'b1;
        rsp_rdata_o  <= dec_double ? '0 : dec_data;
        rsp_corr_o   <= dec_single;
        rsp_uncorr_o <= dec_double;
      end else if (full_wr) begin
        rsp_valid_o <= 1'b1;
      end
    end
  end

  p_stall_blocks_ready_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !req_ready_o);

  p_sub_store_stalls_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_wr |=> stall_o);

  p_no_accept_unowned_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !own_excl_i |-> !req_ready_o);

  p_merge_waits_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (merging && !own_excl_i) |=> (stall_o && !rsp_valid_o));

  p_reject_no_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && bad_align) |-> !arr_we);

  p_flags_exclusive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $onehot0({rsp_corr_o, rsp_uncorr_o, rsp_err_align_o}));

  p_abort_on_double_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (merging && dec_double) |-> !arr_we);

  p_merge_response_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> (rsp_valid_o && !stall_o));

  p_no_spurious_rsp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!accept && !commit) |=> !rsp_valid_o);
endmodule

// File: tb/tb_ecc_merge_store.sv
module tb_ecc_merge_store;
  localparam int DEPTH  = 16;
  localparam int IDX_W  = 4;
  localparam int ADDR_W = 6;
  localparam int CW_W   = 39;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic excl = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0] req_size = 2'd0;
  logic [31:0] req_wdata = '0;
  logic req_ready, stall, rsp_valid, rsp_al, rsp_c, rsp_u;
  logic [31:0] rsp_rdata;
  logic inj_valid = 1'b0;
  logic [IDX_W-1:0] inj_idx = '0;
  logic [CW_W-1:0] inj_flip = '0;

  int checks = 0, failures = 0, cycles = 0;
  string cur_tag = "R1";

  always #10 clk = ~clk;

  ecc_merge_store #(.DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .own_excl_i(excl),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_wdata_i(req_wdata),
    .stall_o(stall), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .rsp_err_align_o(rsp_al), .rsp_corr_o(rsp_c), .rsp_uncorr_o(rsp_u),
    .inj_valid_i(inj_valid), .inj_idx_i(inj_idx), .inj_flip_i(inj_flip)
  );

  // reference model
  logic [31:0]     m_mem  [DEPTH];
  logic [CW_W-1:0] m_flip [DEPTH];
  bit m_busy;
  int h_a, h_sz;
  logic [31:0] h_d;
  bit e_rv, e_al, e_c, e_u;
  logic [31:0] e_rd;
  string e_tag;

  function automatic logic [31:0] merge_ref(logic [31:0] old, int a, int sz, logic [31:0] d);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) begin
      if (sz == 0 && b == a % 4) r[b*8 +: 8] = d[7:0];
      if (sz == 1 && b / 2 == (a / 2) % 2) r[b*8 +: 8] = d[(b%2)*8 +: 8];
    end
    return r;
  endfunction

  function automatic bit bad_ref(int a, int sz);
    return (sz == 3) || (sz == 1 && a % 2 != 0) || (sz == 2 && a % 4 != 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; e_rv = 0;
      for (int w = 0; w < DEPTH; w++) begin m_mem[w] = 0; m_flip[w] = 0; end
    end else begin
      int idx, n;
      e_rv = 0; e_al = 0; e_c = 0; e_u = 0; e_rd = 0; e_tag = cur_tag;
      if (m_busy) begin
        if (excl) begin
          idx = h_a / 4; n = $countones(m_flip[idx]);
          e_rv = 1; e_c = (n == 1); e_u = (n >= 2);
          if (n < 2) begin m_mem[idx] = merge_ref(m_mem[idx], h_a, h_sz, h_d); m_flip[idx] = 0; end
          m_busy = 0;
        end
      end else if (req_valid && excl) begin
        int a, sz;
        a = int'(req_addr); sz = int'(req_size); idx = a / 4;
        if (bad_ref(a, sz)) begin e_rv = 1; e_al = 1; end
        else if (!req_write) begin
          n = $countones(m_flip[idx]);
          e_rv = 1; e_c = (n == 1); e_u = (n >= 2); e_rd = (n >= 2) ? 0 : m_mem[idx];
        end else if (sz == 2) begin
          e_rv = 1; m_mem[idx] = req_wdata; m_flip[idx] = 0;
        end else begin
          m_busy = 1; h_a = a; h_sz = sz; h_d = req_wdata;
        end
      end
      if (inj_valid) m_flip[inj_idx] = m_flip[inj_idx] ^ inj_flip;
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(excl ? "R4" : "R5", "ready", {31'd0, req_ready}, {31'd0, !m_busy && excl});
      chk("R4", "stall", {31'd0, stall}, {31'd0, m_busy});
      chk(e_tag == "" ? "R10" : e_tag, "rsp_valid", {31'd0, rsp_valid}, {31'd0, e_rv});
      if (e_rv && rsp_valid) begin
        chk(e_tag, "rdata", rsp_rdata, e_rd);
        chk(e_tag, "align", {31'd0, rsp_al}, {31'd0, e_al});
        chk(e_tag, "corr", {31'd0, rsp_c}, {31'd0, e_c});
        chk(e_tag, "uncorr", {31'd0, rsp_u}, {31'd0, e_u});
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=done", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic req(bit w, int a, int sz, logic [31:0] d);
    @(posedge clk); #1;
    req_valid = 1; req_write = w; req_addr = ADDR_W'(a); req_size = 2'(sz); req_wdata = d;
    forever begin @(negedge clk); if (req_ready) break; end
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
  endtask

  task automatic inject(int w, logic [CW_W-1:0] m);
    settle();
    @(posedge clk); #1; inj_valid = 1; inj_idx = IDX_W'(w); inj_flip = m;
    @(posedge clk); #1; inj_valid = 0;
  endtask

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset contents
    cur_tag = "R1";
    for (int w = 0; w < 4; w++) req(0, w * 4, 2, 0);
    settle();
    // R2: aligned word stores and readback
    cur_tag = "R2";
    req(1, 0, 2, 32'hDEADBEEF);
    req(1, 4, 2, 32'h01234567);
    req(1, 8, 2, 32'hA5A5A5A5);
    req(1, 12, 2, 32'hFFFFFFFF);
    req(0, 0, 2, 0); req(0, 4, 2, 0);
    // R3: every byte lane and both halfword positions
    cur_tag = "R3";
    for (int b = 0; b < 4; b++) req(1, 16 + b, 0, 32'hFFFFFF10 + b);
    req(0, 16, 2, 0);
    req(1, 4, 1, 32'hBEEF_CAFE); req(0, 4, 2, 0);
    req(1, 6, 1, 32'h0000_1234); req(0, 4, 2, 0);
    req(1, 13, 0, 32'h55); req(0, 12, 2, 0);
    // R5: ownership gating
    cur_tag = "R5";
    settle();
    @(posedge clk); #1 excl = 0;
    req_valid = 1; req_write = 0; req_addr = 0; req_size = 2;
    repeat (4) @(posedge clk);
    #1 req_valid = 0; excl = 1;
    settle();
    req(1, 21, 0, 32'h77);
    excl = 0;
    repeat (3) @(posedge clk);
    #1 excl = 1;
    req(0, 20, 2, 0);
    // R6: rejections leave the array alone
    cur_tag = "R6";
    req(1, 1, 1, 32'h1111); req(1, 2, 2, 32'h2222); req(1, 0, 3, 32'h3333);
    req(0, 1, 2, 0); req(0, 0, 2, 0);
    // R7: single-bit errors
    cur_tag = "R7";
    inject(2, 39'h1 << 17);
    req(0, 8, 2, 0); req(0, 8, 2, 0);
    req(1, 9, 0, 32'h3C);
    req(0, 8, 2, 0);
    inject(3, 39'h1);
    req(0, 12, 2, 0);
    inject(4, 39'h1 << 38);
    req(1, 18, 1, 32'h9876); req(0, 16, 2, 0);
    // R8: double-bit errors
    cur_tag = "R8";
    inject(5, (39'h1 << 3) | (39'h1 << 30));
    req(0, 20, 2, 0);
    req(1, 22, 0, 32'hAB);
    req(0, 20, 2, 0);
    // R9: full-word store cleans
    cur_tag = "R9";
    req(1, 20, 2, 32'h0BADF00D);
    req(0, 20, 2, 0);
    // R10 / R3: mixed traffic
    cur_tag = "R10";
    lfsr = 32'hACE1_2345;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      req(lfsr[3], int'(lfsr[13:8]), int'(lfsr[5:4] == 2'd3 ? (lfsr[6] ? 2'd3 : 2'd0) : lfsr[5:4]),
          {lfsr[15:0], lfsr[31:16]});
    end
    settle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule